// File: doc/BRIEF.md
# Package Idle State Controller

This block chooses one low-power state for the whole package and then carries out the steps needed to enter that state or leave it. Each core reports its own idle depth. The rest of the system reports the deepest state it allows, and a configuration input can cap how deep the package may go. The package target is the least deep of these three limits, rounded down to one of the supported states.

Entering a state is a chain of handshaked actions in a fixed order. The bus ratio drops first, then the voltage ID. After that, and only while the interconnect link holds its L1 grant, the controller gates clocks, gates PLLs, puts memory into self-refresh and puts the shared cache into deep sleep. Leaving a state runs the same chain backwards.

Each action is a level request paired with an acknowledge. The controller never starts a new action while an earlier one is still waiting for its acknowledge. If the target becomes shallower in the middle of an entry, the controller undoes only the actions it has already taken.

Top module: `pidle_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with all cores at code 0, every request output is low.
- R2: The target is the minimum of the shallowest core code, the system permission and the configuration cap, compared as unsigned 3-bit values. It is then rounded down to a supported state: 0 gives C0, 1 and 2 give C1E, 3 to 5 give C3, 6 and 7 give C6.
- R3: C3 is entered only when every core is at code 3 or deeper and the permission is at least 3. If the cores are deeper than C3 but the permission is 3, the package stops at C3.
- R4: C6 is entered only when every core is at code 6 or deeper and the permission is at least 6.
- R5: A cap value of 1 limits the package to C1E, whatever the core depths.
- R6: Entry lowers the bus ratio first (ratio_low_req_o). The voltage ID request (vid_low_req_o) rises only after the ratio acknowledge is high. In C1E exactly these two requests are held.
- R7: In C3 with link_l1_grant_i high, the controller also raises the clock-gate, PLL-gate and memory self-refresh requests, in that order. Without the grant, only the ratio and voltage requests are held.
- R8: In C6 with the grant, the cache deep-sleep request is added on top of the C3 set. C6 without the grant holds only the ratio and voltage requests.
- R9: Exit releases requests in reverse order: cache, self-refresh, PLL, clock, voltage, ratio. A request drops only after every later step's acknowledge is low.
- R10: A request that differs from its acknowledge keeps its level until the acknowledge matches. No other request changes while one is waiting.
- R11: If the target becomes shallower during entry, steps not yet started are never raised. The steps already taken are released in reverse order, and the held requests always form a contiguous run starting at the ratio step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_state_i | input | 3*NUM_CORES | Idle code per core, core i at bits [3i+2:3i] |
| sys_permit_i | input | 3 | Deepest state the system allows |
| link_l1_grant_i | input | 1 | Interconnect link L1 granted |
| cfg_cap_i | input | 3 | Configuration depth cap |
| ratio_low_req_o | output | 1 | Request the lowest bus ratio |
| ratio_low_ack_i | input | 1 | Bus ratio acknowledge |
| vid_low_req_o | output | 1 | Request the lowest voltage ID |
| vid_low_ack_i | input | 1 | Voltage ID acknowledge |
| clk_gate_req_o | output | 1 | Gate selected clocks |
| clk_gate_ack_i | input | 1 | Clock gate acknowledge |
| pll_gate_req_o | output | 1 | Gate PLLs |
| pll_gate_ack_i | input | 1 | PLL gate acknowledge |
| mem_sref_req_o | output | 1 | Memory self-refresh request |
| mem_sref_ack_i | input | 1 | Self-refresh acknowledge |
| cache_sleep_req_o | output | 1 | Shared cache deep-sleep request |
| cache_sleep_ack_i | input | 1 | Cache sleep acknowledge |

## Verification
The tricky overlap is a target change that arrives while a step is still waiting for its acknowledge. The new, shallower target must not advance the chain. Only after that acknowledge arrives may the controller start unwinding. The bench provokes this by dropping one core to C0 just after the clock-gate request rises, with a ten-cycle acknowledge delay. It then checks that the PLL, self-refresh and cache requests never rise, that all requests end low, and that each release waits for the acknowledges above it.

// File: rtl/pidle_pkg.sv
package pidle_pkg;

    localparam int CODE_W = 3;
    localparam int STEP_N = 6;

    // step indices, entry order
    localparam int STP_RATIO = 0;
    localparam int STP_VID   = 1;
    localparam int STP_CLK   = 2;
    localparam int STP_PLL   = 3;
    localparam int STP_SREF  = 4;
    localparam int STP_CACHE = 5;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [STEP_N-1:0] step_vec_t;

    typedef enum logic [CODE_W-1:0] {
        PS_C0  = 3'd0,
        PS_C1E = 3'd1,
        PS_C3  = 3'd3,
        PS_C6  = 3'd6
    } pstate_e;

    function automatic pstate_e quantize(code_t c);
        if (c >= 3'd6)      return PS_C6;
        else if (c >= 3'd3) return PS_C3;
        else if (c >= 3'd1) return PS_C1E;
        else                return PS_C0;
    endfunction

    function automatic code_t code_min(code_t a, code_t b);
        return (a < b) ? a : b;
    endfunction

    // contiguous run of steps from the ratio step upward
    function automatic step_vec_t run_of(int n);
        step_vec_t v;
        v = '0;
        for (int i = 0; i < STEP_N; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic step_vec_t steps_for(pstate_e s, logic l1);
        case (s)
            PS_C1E:  return run_of(STP_CLK);
            PS_C3:   return l1 ? run_of(STP_CACHE) : run_of(STP_CLK);
            PS_C6:   return l1 ? run_of(STEP_N)    : run_of(STP_CLK);
            default: return '0;
        endcase
    endfunction

    function automatic logic is_run(step_vec_t v);
        step_vec_t nxt;
        nxt = v + step_vec_t'(1);
        return (v & nxt) == '0;
    endfunction

    function automatic step_vec_t grow(step_vec_t v);
        return (v << 1) | step_vec_t'(1);
    endfunction

    function automatic step_vec_t shrink(step_vec_t v);
        return v >> 1;
    endfunction

endpackage

// File: rtl/pidle_resolve.sv
module pidle_resolve
    import pidle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CORES*CODE_W-1:0] core_codes,
    input  code_t                       permit,
    input  code_t                       cap,
    input  logic                        l1_grant,
    output step_vec_t                   want
);

    code_t   shallow;
    code_t   limit;
    pstate_e tgt_d;
    pstate_e tgt_q;
    step_vec_t want_q;

    always_comb begin
        shallow = '1;
        for (int i = 0; i < NUM_CORES; i++) begin
            shallow = code_min(shallow, core_codes[i*CODE_W +: CODE_W]);
        end
        limit = code_min(code_min(shallow, permit), cap);
        tgt_d = quantize(limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= PS_C0;
            want_q <= '0;
        end else begin
            tgt_q  <= tgt_d;
            want_q <= steps_for(tgt_d, l1_grant);
        end
    end

    assign want = want_q;

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        code_t'(tgt_q) <= $past(cap)) else $error("cap exceeded"); // R5
    AST_CACHE_ONLY_C6: assert property (@(posedge clk) disable iff (rst)
        want_q[STP_CACHE] |-> (tgt_q == PS_C6) && want_q[STP_SREF]) else $error("cache step outside C6"); // R8
    AST_WANT_RUN: assert property (@(posedge clk) disable iff (rst)
        is_run(want_q)) else $error("want not contiguous"); // R7

endmodule

// File: rtl/pidle_hs_chan.sv
module pidle_hs_chan (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic req_o,
    output logic busy_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)        req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;
        else if (clr_i) req_q <= 1'b0;
    end

    assign req_o  = req_q;
    assign busy_o = req_q ^ ack_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_q && !ack_i) |=> req_q) else $error("request dropped early"); // R10
    AST_REL_HELD: assert property (@(posedge clk) disable iff (rst)
        (!req_q && ack_i) |=> !req_q) else $error("release reverted early"); // R10

endmodule

// File: rtl/pidle_step_seq.sv
module pidle_step_seq
    import pidle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_vec_t want,
    input  step_vec_t req,
    input  step_vec_t ack,
    input  step_vec_t busy,
    output step_vec_t set_o,
    output step_vec_t clr_o
);

    logic any_busy;

    assign any_busy = |busy;

    always_comb begin
        set_o = '0;
        clr_o = '0;
        if (!any_busy) begin
            if (req > want)      clr_o = req ^ shrink(req);
            else if (want > req) set_o = req ^ grow(req);
        end
    end

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        $countones(req ^ ack) <= 1) else $error("two steps pending"); // R10
    AST_RUN_SHAPE: assert property (@(posedge clk) disable iff (rst)
        is_run(req)) else $error("held steps not contiguous"); // R11

    for (genvar k = 1; k < STEP_N; k++) begin : g_entry_order
        AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (rst)
            $rose(req[k]) |-> ack[k-1]) else $error("entry out of order"); // R6
    end

    for (genvar k = 0; k < STEP_N-1; k++) begin : g_exit_order
        AST_EXIT_ORDER: assert property (@(posedge clk) disable iff (rst)
            $fell(req[k]) |-> !ack[k+1]) else $error("exit out of order"); // R9
    end

endmodule

// File: rtl/pidle_ctrl.sv
module pidle_ctrl
    import pidle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CORES*3-1:0] core_state_i,
    input  logic [2:0]             sys_permit_i,
    input  logic                   link_l1_grant_i,
    input  logic [2:0]             cfg_cap_i,
    output logic                   ratio_low_req_o,
    input  logic                   ratio_low_ack_i,
    output logic                   vid_low_req_o,
    input  logic                   vid_low_ack_i,
    output logic                   clk_gate_req_o,
    input  logic                   clk_gate_ack_i,
    output logic                   pll_gate_req_o,
    input  logic                   pll_gate_ack_i,
    output logic                   mem_sref_req_o,
    input  logic                   mem_sref_ack_i,
    output logic                   cache_sleep_req_o,
    input  logic                   cache_sleep_ack_i
);

    step_vec_t want;
    step_vec_t req;
    step_vec_t ack;
    step_vec_t busy;
    step_vec_t set_v;
    step_vec_t clr_v;

    assign ack[STP_RATIO] = ratio_low_ack_i;
    assign ack[STP_VID]   = vid_low_ack_i;
    assign ack[STP_CLK]   = clk_gate_ack_i;
    assign ack[STP_PLL]   = pll_gate_ack_i;
    assign ack[STP_SREF]  = mem_sref_ack_i;
    assign ack[STP_CACHE] = cache_sleep_ack_i;

    pidle_resolve #(.NUM_CORES(NUM_CORES)) u_resolve (
        .clk        (clk),
        .rst        (rst),
        .core_codes (core_state_i),
        .permit     (sys_permit_i),
        .cap        (cfg_cap_i),
        .l1_grant   (link_l1_grant_i),
        .want       (want)
    );

    pidle_step_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .want  (want),
        .req   (req),
        .ack   (ack),
        .busy  (busy),
        .set_o (set_v),
        .clr_o (clr_v)
    );

    for (genvar s = 0; s < STEP_N; s++) begin : g_chan
        pidle_hs_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[s]),
            .clr_i  (clr_v[s]),
            .ack_i  (ack[s]),
            .req_o  (req[s]),
            .busy_o (busy[s])
        );
    end

    assign ratio_low_req_o   = req[STP_RATIO];
    assign vid_low_req_o     = req[STP_VID];
    assign clk_gate_req_o    = req[STP_CLK];
    assign pll_gate_req_o    = req[STP_PLL];
    assign mem_sref_req_o    = req[STP_SREF];
    assign cache_sleep_req_o = req[STP_CACHE];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (req == '0)) else $error("requests active after reset"); // R1

endmodule

// File: tb/pidle_ctrl_bench.sv
`timescale 1ns/1ps
module pidle_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cores = '0;
    logic [2:0]  permit = 3'd6;
    logic [2:0]  cap = 3'd7;
    logic        l1 = 1'b1;
    logic [5:0]  req;
    logic [5:0]  ack = '0;
    logic [5:0]  prev_req = '0;
    int          cnt [6];
    int          ack_lat = 2;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          rise_vid = 0;
    int          fall_ratio = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pidle_ctrl #(.NUM_CORES(4)) u_pidle_ctrl (
        .clk(clk), .rst(rst), .core_state_i(cores), .sys_permit_i(permit),
        .link_l1_grant_i(l1), .cfg_cap_i(cap),
        .ratio_low_req_o(req[0]),   .ratio_low_ack_i(ack[0]),
        .vid_low_req_o(req[1]),     .vid_low_ack_i(ack[1]),
        .clk_gate_req_o(req[2]),    .clk_gate_ack_i(ack[2]),
        .pll_gate_req_o(req[3]),    .pll_gate_ack_i(ack[3]),
        .mem_sref_req_o(req[4]),    .mem_sref_ack_i(ack[4]),
        .cache_sleep_req_o(req[5]), .cache_sleep_ack_i(ack[5])
    );

    // order monitor and acknowledge responder, both on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 6; k++) begin
                if (req[k] && !prev_req[k]) begin
                    if (k == 1) rise_vid++;
                    for (int j = 0; j < k; j++) begin
                        if (!ack[j]) begin
                            errors++;
                            $display("FAIL R6 step %0d rose with ack[%0d]=%0d expected 1", k, j, ack[j]);
                        end
                    end
                end
                if (!req[k] && prev_req[k]) begin
                    if (k == 0) fall_ratio++;
                    for (int j = k + 1; j < 6; j++) begin
                        if (ack[j]) begin
                            errors++;
                            $display("FAIL R9 step %0d fell with ack[%0d]=%0d expected 0", k, j, ack[j]);
                        end
                    end
                end
            end
        end
        prev_req = req;
        for (int k = 0; k < 6; k++) begin
            if (req[k] != ack[k]) begin
                cnt[k]++;
                if (cnt[k] >= ack_lat) begin
                    ack[k] = req[k];
                    cnt[k] = 0;
                end
            end else begin
                cnt[k] = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog cycles=%0d expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_vec(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_req(int k, output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (req[k]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // {cores as four octal digits, permit, cap, l1, expected requests [cache..ratio]}
    localparam int NV = 14;
    localparam logic [24:0] VEC [NV] = '{
        {12'o0000, 3'd6, 3'd7, 1'b1, 6'b000000},  // R2 all active
        {12'o1111, 3'd6, 3'd7, 1'b1, 6'b000011},  // R6 C1E
        {12'o6366, 3'd6, 3'd7, 1'b1, 6'b011111},  // R3 shallowest core limits
        {12'o6666, 3'd3, 3'd7, 1'b1, 6'b011111},  // R3 permission stops at C3
        {12'o7777, 3'd6, 3'd7, 1'b1, 6'b111111},  // R4 C6 with grant
        {12'o6666, 3'd6, 3'd7, 1'b0, 6'b000011},  // R8 C6 without grant
        {12'o6666, 3'd6, 3'd1, 1'b1, 6'b000011},  // R5 cap to C1E
        {12'o3333, 3'd6, 3'd7, 1'b0, 6'b000011},  // R7 C3 without grant
        {12'o6666, 3'd1, 3'd7, 1'b1, 6'b000011},  // R2 permission limits
        {12'o6606, 3'd6, 3'd7, 1'b1, 6'b000000},  // R2 one core active
        {12'o4444, 3'd6, 3'd7, 1'b1, 6'b011111},  // R2 code 4 rounds to C3
        {12'o6666, 3'd6, 3'd6, 1'b1, 6'b111111},  // R8 C6 with grant
        {12'o3333, 3'd6, 3'd7, 1'b1, 6'b011111},  // R9 back off to C3, R7
        {12'o2222, 3'd6, 3'd7, 1'b1, 6'b000011}   // R2 code 2 rounds to C1E
    };

    initial begin
        bit ok;
        logic [5:0] seen;
        for (int k = 0; k < 6; k++) cnt[k] = 0;
        repeat (4) @(negedge clk);
        check_vec("R1 requests during reset", req, 6'b000000);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R1 requests after reset", req, 6'b000000);

        for (int v = 0; v < NV; v++) begin
            cores  = VEC[v][24:13];
            permit = VEC[v][12:10];
            cap    = VEC[v][9:7];
            l1     = VEC[v][6];
            settle(100);
            check_vec($sformatf("R2 table row %0d requests", v), req, VEC[v][5:0]);
            check_vec($sformatf("R10 table row %0d acks settled", v), ack, VEC[v][5:0]);
        end

        // R10: slow acknowledge holds the chain
        cores = 12'o0000; cap = 3'd7; permit = 3'd6; l1 = 1'b1;
        settle(100);
        ack_lat = 40;
        cores = 12'o1111;
        wait_req(0, ok);
        check_vec("R10 ratio request raised", {5'b0, ok}, 6'b000001);
        settle(20);
        check_vec("R10 hold while ratio ack pending", req, 6'b000001);
        settle(200);
        check_vec("R10 C1E reached after slow acks", req, 6'b000011);
        cores = 12'o0000;
        settle(200);
        check_vec("R9 slow exit to C0", req, 6'b000000);

        // R11: abort while clock-gate step pending
        ack_lat = 10;
        cores = 12'o6666;
        wait_req(2, ok);
        check_vec("R11 clock gate raised", {5'b0, ok}, 6'b000001);
        cores = 12'o6660;
        seen = req;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            seen = seen | req;
        end
        check_vec("R11 later steps never raised", {seen[5:3], 3'b000}, 6'b000000);
        check_vec("R11 unwound to C0", req, 6'b000000);

        checks++;
        if (rise_vid == 0) begin
            errors++;
            $display("FAIL R6 voltage request rises=%0d expected >0", rise_vid);
        end
        checks++;
        if (fall_ratio == 0) begin
            errors++;
            $display("FAIL R9 ratio releases=%0d expected >0", fall_ratio);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule